// File: doc/BRIEF.md
# DMA Engine Global Control Register

This block is the global control and status word of a multi-channel DMA engine, together with the small amount of logic that decides whether the engine may start a new channel. Software writes the 32-bit word through a simple write strobe and reads it back through a read bus that always shows the live contents. The engine supplies four inputs:
- whether a channel is currently executing;
- a strobe that marks the end of each read/write pair;
- an error pulse;
- the chip's debug-mode state.

From the stored fields and these inputs the block drives a start-permit signal. New channel starts are held off by the halt bit, by a debug stall when debug stalling is enabled, and by halt-on-error, which sets halt by itself when an error arrives. A channel that is already executing is never interrupted by these gates.

Two self-clearing cancel bits let software stop the executing channel. Either bit takes effect only at the end of the current read/write pair. The plain cancel retires the channel as a normal completion. The error cancel also pulses an error-status update strobe, which the error-status logic and the interrupt controller use to record the error and, optionally, raise an interrupt.

The arbitration, linking and loop-mapping fields are only stored and read back for the rest of the engine.

Top module: `dma_gctl`

## Requirements
- R1: After reset the read bus shows 0x0000_0400, start_permit_o is 1 and both cancel requests and err_status_upd_o are 0.
- R2: A write stores bit 1 (debug stall enable), bit 2 (channel round-robin), bit 3 (group round-robin), bit 4 (halt on error), bit 5 (halt), bit 6 (continuous link), bit 7 (minor loop mapping), bit 8 (group 0 priority) and bit 10 (group 1 priority), and these read back on the read bus from the cycle after the write.
- R3: Writes to bit 31 and to the unused positions 0, 9, 11 to 15 and 18 to 30 are ignored, and those positions read as 0, except bit 31.
- R4: Bit 31 of the read bus equals chan_active_i: it is 1 while a channel executes and 0 while idle.
- R5: While bit 5 (halt) is 1, start_permit_o is 0. Once halt is written to 0, start_permit_o is 1 again, provided no debug stall applies.
- R6: While bit 1 is 1 and dbg_mode_i is 1, start_permit_o is 0. It returns to 1 when dbg_mode_i falls or bit 1 is written to 0. dbg_mode_i has no effect while bit 1 is 0.
- R7: When bit 4 (halt on error) is 1, an eng_err_i pulse sets bit 5 at the next clock edge, and start_permit_o stays 0 until software writes bit 5 to 0. When bit 4 is 0, eng_err_i leaves bit 5 unchanged.
- R8: Writing 1 to bit 17 (cancel) while a channel executes sets the bit and raises cancel_req_o. Both stay 1 until a cycle with rw_pair_done_i = 1, and read 0 from the next cycle on. No err_status_upd_o pulse follows.
- R9: Writing 1 to bit 16 (error cancel) while a channel executes raises err_cancel_req_o until a cycle with rw_pair_done_i = 1. In the cycle after that one, bit 16 reads 0 and err_status_upd_o is 1 for exactly one cycle.
- R10: A cancel or error-cancel bit written to 1 while chan_active_i is 0 reads 1 for one cycle and then 0. No request and no err_status_upd_o pulse is produced.
- R11: Writing 0 to bit 16 or bit 17 does not clear a pending cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en_i | input | 1 | Write strobe for the control word |
| reg_wr_data_i | input | 32 | Write data |
| reg_rd_data_o | output | 32 | Live contents of the control word, active flag in bit 31 |
| dbg_mode_i | input | 1 | Chip is in debug mode |
| eng_err_i | input | 1 | One-cycle error pulse from the transfer engine |
| chan_active_i | input | 1 | A channel is executing |
| rw_pair_done_i | input | 1 | Last write of the current read/write pair completes this cycle |
| start_permit_o | output | 1 | A new channel may start |
| cancel_req_o | output | 1 | Request to stop the executing channel as a normal completion |
| err_cancel_req_o | output | 1 | Request to stop the executing channel as an error |
| err_status_upd_o | output | 1 | One-cycle pulse: the error status must record an error cancel |

## Verification
The assertions assume the following about the inputs:
- eng_err_i is a single-cycle pulse;
- rw_pair_done_i is asserted only while chan_active_i is 1;
- software does not write a cancel bit in the very cycle in which a pending cancel is honored.

The directed tasks raise rw_pair_done_i only inside a busy window and pulse eng_err_i for one cycle. Every write is separated from the strobes that could compete with it, so the stimulus stays inside these assumptions.

// File: rtl/dma_gctl_pkg.sv
package dma_gctl_pkg;
  localparam int unsigned REG_W = 32;

  // Field positions decoded by the rest of the engine
  localparam int unsigned B_DBG_EN   = 1;
  localparam int unsigned B_CH_RR    = 2;
  localparam int unsigned B_GRP_RR   = 3;
  localparam int unsigned B_HALT_ERR = 4;
  localparam int unsigned B_HALT     = 5;
  localparam int unsigned B_CONT_LNK = 6;
  localparam int unsigned B_LOOP_MAP = 7;
  localparam int unsigned B_G0_PRI   = 8;
  localparam int unsigned B_G1_PRI   = 10;
  localparam int unsigned B_ERR_CNCL = 16;
  localparam int unsigned B_CNCL     = 17;
  localparam int unsigned B_ACTIVE   = 31;

  localparam int unsigned N_CNCL = 2;

  localparam logic [REG_W-1:0] CFG_MASK  = 32'h0000_05FE;
  localparam logic [REG_W-1:0] CFG_RESET = 32'h0000_0400;

  function automatic int unsigned cncl_bit(input int unsigned idx);
    return (idx == 0) ? B_ERR_CNCL : B_CNCL;
  endfunction
endpackage

// File: rtl/dma_gctl_cfg.sv
module dma_gctl_cfg
  import dma_gctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             err_i,
  output logic [REG_W-1:0] cfg_o
);
  logic [REG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;
  logic             err_halt;

  assign err_halt = err_i & cfg_q[B_HALT_ERR];
  assign cfg_en   = wr_en_i | err_halt;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) cfg_d = wr_data_i & CFG_MASK;
    if (err_halt) cfg_d[B_HALT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/dma_gctl_cncl.sv
module dma_gctl_cncl #(
  parameter bit REPORT_ERR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic busy_i,
  input  logic pair_done_i,
  output logic pend_o,
  output logic req_o,
  output logic upd_o
);
  logic pend_q, pend_d, pend_en;
  logic honor;

  assign honor   = pend_q & busy_i & pair_done_i;
  // An idle engine has nothing to cancel, so the bit drops at once
  assign pend_d  = set_i | (pend_q & busy_i & ~pair_done_i);
  assign pend_en = set_i | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & busy_i;

  if (REPORT_ERR) begin : g_rep
    logic upd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q <= 1'b0;
      else        upd_q <= honor;
    end
    assign upd_o = upd_q;
  end else begin : g_norep
    assign upd_o = 1'b0;
  end
endmodule

// File: rtl/dma_gctl_gate.sv
module dma_gctl_gate (
  input  logic halt_i,
  input  logic dbg_en_i,
  input  logic dbg_mode_i,
  output logic permit_o
);
  assign permit_o = ~halt_i & ~(dbg_en_i & dbg_mode_i);
endmodule

// File: rtl/dma_gctl.sv
module dma_gctl
  import dma_gctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en_i,
  input  logic [31:0] reg_wr_data_i,
  output logic [31:0] reg_rd_data_o,
  input  logic        dbg_mode_i,
  input  logic        eng_err_i,
  input  logic        chan_active_i,
  input  logic        rw_pair_done_i,
  output logic        start_permit_o,
  output logic        cancel_req_o,
  output logic        err_cancel_req_o,
  output logic        err_status_upd_o
);
  logic [REG_W-1:0]  cfg;
  logic [N_CNCL-1:0] pend, req, upd;

  dma_gctl_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_en_i),
    .wr_data_i (reg_wr_data_i),
    .err_i     (eng_err_i),
    .cfg_o     (cfg)
  );

  for (genvar i = 0; i < N_CNCL; i++) begin : g_cncl
    dma_gctl_cncl #(.REPORT_ERR(i == 0)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (reg_wr_en_i & reg_wr_data_i[cncl_bit(i)]),
      .busy_i      (chan_active_i),
      .pair_done_i (rw_pair_done_i),
      .pend_o      (pend[i]),
      .req_o       (req[i]),
      .upd_o       (upd[i])
    );
  end

  dma_gctl_gate u_gate (
    .halt_i     (cfg[B_HALT]),
    .dbg_en_i   (cfg[B_DBG_EN]),
    .dbg_mode_i (dbg_mode_i),
    .permit_o   (start_permit_o)
  );

  always_comb begin
    reg_rd_data_o = cfg;
    for (int i = 0; i < N_CNCL; i++) reg_rd_data_o[cncl_bit(i)] = pend[i];
    reg_rd_data_o[B_ACTIVE] = chan_active_i;
  end

  assign err_cancel_req_o = req[0];
  assign cancel_req_o     = req[1];
  assign err_status_upd_o = |upd;
endmodule

// File: rtl/dma_gctl_chk.sv
module dma_gctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en_i,
  input logic [31:0] reg_rd_data_o,
  input logic        dbg_mode_i,
  input logic        eng_err_i,
  input logic        chan_active_i,
  input logic        rw_pair_done_i,
  input logic        start_permit_o,
  input logic        cancel_req_o,
  input logic        err_cancel_req_o,
  input logic        err_status_upd_o
);
  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data_o & 32'h7FFC_FA01) == 32'h0);

  assert_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data_o[31] == chan_active_i);

  assert_halt_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data_o[5] |-> !start_permit_o);

  assert_dbg_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data_o[1] && dbg_mode_i) |-> !start_permit_o);

  assert_err_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_err_i && reg_rd_data_o[4]) |=> reg_rd_data_o[5]);

  assert_cncl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_req_o && !rw_pair_done_i) |=> reg_rd_data_o[17]);

  assert_err_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_status_upd_o |-> $past(err_cancel_req_o && rw_pair_done_i));

  assert_idle_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data_o[17] && !chan_active_i && !reg_wr_en_i) |=> !reg_rd_data_o[17]);
endmodule

bind dma_gctl dma_gctl_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .reg_wr_en_i      (reg_wr_en_i),
  .reg_rd_data_o    (reg_rd_data_o),
  .dbg_mode_i       (dbg_mode_i),
  .eng_err_i        (eng_err_i),
  .chan_active_i    (chan_active_i),
  .rw_pair_done_i   (rw_pair_done_i),
  .start_permit_o   (start_permit_o),
  .cancel_req_o     (cancel_req_o),
  .err_cancel_req_o (err_cancel_req_o),
  .err_status_upd_o (err_status_upd_o)
);

// File: tb/sim_dma_gctl.sv
`timescale 1ns/1ps
module sim_dma_gctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dbg = 1'b0, err = 1'b0, busy = 1'b0, pdone = 1'b0;
  logic        permit, creq, ecreq, eupd;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dma_gctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en_i(wr_en), .reg_wr_data_i(wr_data),
    .reg_rd_data_o(rd_data), .dbg_mode_i(dbg), .eng_err_i(err),
    .chan_active_i(busy), .rw_pair_done_i(pdone), .start_permit_o(permit),
    .cancel_req_o(creq), .err_cancel_req_o(ecreq), .err_status_upd_o(eupd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd", rd_data, 32'h0000_0400);
    chk("R1 permit", {31'b0, permit}, 32'd1);
    chk("R1 reqs", {29'b0, creq, ecreq, eupd}, 32'd0);
  endtask

  task automatic t_fields;
    wr(32'hFFFF_FFFF);
    chk("R2 R3 all-ones", rd_data, 32'h0003_05FE);
    tick();
    chk("R10 idle cancels drop", rd_data, 32'h0000_05FE);
    chk("R10 no reqs", {29'b0, creq, ecreq, eupd}, 32'd0);
    wr(32'h0000_0000);
    chk("R2 cleared", rd_data, 32'h0000_0000);
    wr(32'h8000_014C);
    chk("R2 R3 pattern", rd_data, 32'h0000_014C);
    wr(32'h7FFC_FA01);
    chk("R3 unused ignored", rd_data, 32'h0000_0000);
  endtask

  task automatic t_active;
    busy = 1'b1; tick();
    chk("R4 busy", {31'b0, rd_data[31]}, 32'd1);
    busy = 1'b0; tick();
    chk("R4 idle", {31'b0, rd_data[31]}, 32'd0);
  endtask

  task automatic t_halt;
    wr(32'h0000_0020);
    chk("R5 halted", {31'b0, permit}, 32'd0);
    wr(32'h0000_0000);
    chk("R5 resumed", {31'b0, permit}, 32'd1);
  endtask

  task automatic t_debug;
    dbg = 1'b1; tick();
    chk("R6 dbg ignored when disabled", {31'b0, permit}, 32'd1);
    wr(32'h0000_0002);
    chk("R6 stalled", {31'b0, permit}, 32'd0);
    dbg = 1'b0; tick();
    chk("R6 dbg exit", {31'b0, permit}, 32'd1);
    dbg = 1'b1; tick();
    chk("R6 stalled again", {31'b0, permit}, 32'd0);
    wr(32'h0000_0000);
    chk("R6 bit cleared", {31'b0, permit}, 32'd1);
    dbg = 1'b0;
  endtask

  task automatic t_err_halt;
    err = 1'b1; tick(); err = 1'b0; tick();
    chk("R7 no hoe", {31'b0, rd_data[5]}, 32'd0);
    wr(32'h0000_0010);
    err = 1'b1; tick(); err = 1'b0;
    chk("R7 halt set", {31'b0, rd_data[5]}, 32'd1);
    tick(3);
    chk("R7 stays halted", {31'b0, permit}, 32'd0);
    wr(32'h0000_0010);
    chk("R7 released", {31'b0, permit}, 32'd1);
    wr(32'h0000_0000);
  endtask

  task automatic t_cancel;
    busy = 1'b1;
    wr(32'h0002_0000);
    chk("R8 pending", {30'b0, rd_data[17], creq}, 32'd3);
    tick(2);
    wr(32'h0000_0000);
    chk("R11 zero write keeps", {30'b0, rd_data[17], creq}, 32'd3);
    pdone = 1'b1; tick(); pdone = 1'b0;
    chk("R8 honored", {29'b0, rd_data[17], creq, eupd}, 32'd0);
    busy = 1'b0; tick();
  endtask

  task automatic t_err_cancel;
    busy = 1'b1;
    wr(32'h0001_0000);
    chk("R9 pending", {29'b0, rd_data[16], ecreq, creq}, 32'd6);
    tick();
    pdone = 1'b1; tick(); pdone = 1'b0;
    chk("R9 honored", {29'b0, rd_data[16], ecreq, eupd}, 32'd1);
    tick();
    chk("R9 single pulse", {31'b0, eupd}, 32'd0);
    busy = 1'b0; tick();
    wr(32'h0001_0000);
    chk("R10 idle ecx", {29'b0, rd_data[16], ecreq, eupd}, 32'd4);
    tick();
    chk("R10 idle ecx drop", {29'b0, rd_data[16], ecreq, eupd}, 32'd0);
    tick();
    chk("R10 no pulse", {31'b0, eupd}, 32'd0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fields();
    t_active();
    t_halt();
    t_debug();
    t_err_halt();
    t_cancel();
    t_err_cancel();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule